// File: doc/BRIEF.md
# Bus Register Select Decoder

This block sits on the slave side of a multiplexed address/data bus. The bus runs a sync strobe around each transaction. On the cycle the strobe is first seen high, the block captures the low address bits and a device-enable. For the rest of that transaction it drives one of four word-register selects. From the data strobes it forms a read-word gate and a pair of byte write strobes.

The block also answers the bus master with a reply handshake. A parameterised cycle counter delays that reply, which stands in for the analog delay network of a discrete part. A vector input can request the reply on its own, with no transaction in progress. All inputs are taken to be synchronous to `clk`, and reset is synchronous and active high.

Top module: `bsel_decoder`

## Requirements
- R1: While `rst` is high, and on the first clock after it, every output is low.
- R2: `dal_i` and `enb_i` are captured only at the clock edge where `sync_i` is high and was low at the previous edge. Changes to them later in the same transaction have no effect on `sel_o`.
- R3: `sel_o` is one-hot or zero. Bit k (k = 0..3, the word registers at byte offsets 0, 2, 4 and 6) asserts when the captured `dal_i[2:1]` equals k, and only if `enb_i` was high at capture.
- R4: The selects assert from the cycle after capture and stay unchanged while `sync_i` stays high. They fall in the same cycle that `sync_i` goes low.
- R5: `rd_word_o` is high exactly when `din_i` is high and the transaction is active. Active means `sync_i` is high now and was high at the previous edge.
- R6: A word write asserts both `wr_lo_o` and `wr_hi_o` while `dout_i` is high in an active transaction. A word write is `dout_i` high with `wtbt_i` low.
- R7: A byte write asserts only `wr_lo_o` when the captured `dal_i[0]` is 0, and only `wr_hi_o` when it is 1. A byte write is `dout_i` high with `wtbt_i` high.
- R8: The reply trigger is `vec_i`, or `din_i` or `dout_i` in an active transaction whose enable was captured high. `reply_o` asserts once the trigger has been high at `DELAY_CYC` consecutive clock edges, and drops at once with the trigger.
- R9: Any cycle with the trigger low restarts the delay count from zero.
- R10: `vec_i` produces the delayed reply whatever the state of `sync_i` and of the captured enable.
- R11: With `sync_i` low, `sel_o`, `rd_word_o`, `wr_lo_o` and `wr_hi_o` are all low. `reply_o` can then come only from `vec_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_i | input | 1 | Transaction sync strobe, high = active |
| enb_i | input | 1 | Device enable, captured with the address |
| dal_i | input | ADDR_W (3) | Low address bits from the multiplexed bus |
| wtbt_i | input | 1 | Write width: high = byte, low = word |
| din_i | input | 1 | Data-in (read) strobe |
| dout_i | input | 1 | Data-out (write) strobe |
| vec_i | input | 1 | Vector reply request |
| sel_o | output | 2**(ADDR_W-1) (4) | One-hot word-register selects |
| rd_word_o | output | 1 | Read-word gate |
| wr_lo_o | output | 1 | Low-byte write strobe |
| wr_hi_o | output | 1 | High-byte write strobe |
| reply_o | output | 1 | Delayed reply handshake |

## Verification
The assertions assume that all inputs change only between clock edges and are already synchronous. They also assume `rst` is held high over the first edges, so that the previous-sync register and the count start from a known zero. The stimulus drives every input on the falling clock edge. Random sync pulses last several cycles, so that captures, held selects, strobes inside and outside a transaction, and broken trigger runs all occur. `vec_i` is pulsed independently of `sync_i`, so that the vector path is exercised both inside and outside a transaction.

// File: rtl/bsel_pkg.sv
package bsel_pkg;

    // Kind of write decoded from the data-out strobe, width line and A0
    typedef enum logic [1:0] {
        WR_NONE = 2'b00,
        WR_LOW  = 2'b01,
        WR_HIGH = 2'b10,
        WR_BOTH = 2'b11
    } wr_kind_e;

    // Transaction-time control inputs bundled together
    typedef struct packed {
        logic active;
        logic din;
        logic dout;
        logic byte_mode;
    } strobe_ctl_t;

    function automatic wr_kind_e decode_write(input strobe_ctl_t c, input logic a0);
        wr_kind_e k;
        k = WR_NONE;
        if (c.active && c.dout) begin
            if (!c.byte_mode)  k = WR_BOTH;
            else if (a0)       k = WR_HIGH;
            else               k = WR_LOW;
        end
        return k;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/bsel_addr_trap.sv
module bsel_addr_trap #(
    parameter int unsigned ADDR_W  = 3,
    localparam int unsigned NUM_SEL = 1 << (ADDR_W - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_i,
    input  logic              enb_i,
    input  logic [ADDR_W-1:0] dal_i,
    output logic              active_o,
    output logic              hit_o,
    output logic              a0_o,
    output logic [NUM_SEL-1:0] sel_o
);
    logic              sync_q;
    logic              hit_q;
    logic [ADDR_W-1:0] addr_q;
    logic              capture;

    assign capture = sync_i && !sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            hit_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            sync_q <= sync_i;
            if (capture) begin
                addr_q <= dal_i;
                hit_q  <= enb_i;
            end else if (!sync_i) begin
                hit_q  <= 1'b0;
            end
        end
    end

    assign active_o = sync_i && sync_q;
    assign hit_o    = hit_q;
    assign a0_o     = addr_q[0];

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        assign sel_o[g] = active_o && hit_q && (addr_q[ADDR_W-1:1] == (ADDR_W-1)'(g));
    end

    assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_o));

    assert_sel_held_R4: assert property (@(posedge clk) disable iff (rst)
        (active_o && $past(active_o)) |-> $stable(sel_o));

endmodule

// File: rtl/bsel_strobe_dec.sv
module bsel_strobe_dec
    import bsel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic din_i,
    input  logic dout_i,
    input  logic wtbt_i,
    input  logic a0_i,
    output logic rd_word_o,
    output logic wr_lo_o,
    output logic wr_hi_o
);
    strobe_ctl_t ctl;
    wr_kind_e    kind;

    always_comb begin
        ctl.active    = active_i;
        ctl.din       = din_i;
        ctl.dout      = dout_i;
        ctl.byte_mode = wtbt_i;
        kind          = decode_write(ctl, a0_i);
    end

    assign rd_word_o = ctl.active && ctl.din;
    assign wr_lo_o   = kind[0];
    assign wr_hi_o   = kind[1];

    assert_byte_excl_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_lo_o && wr_hi_o) |-> !wtbt_i);

    assert_wr_needs_out_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_lo_o || wr_hi_o) |-> (dout_i && active_i));

endmodule

// File: rtl/bsel_reply_timer.sv
module bsel_reply_timer
    import bsel_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 4,
    localparam int unsigned CNT_W    = cnt_width(DELAY_CYC)
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic reply_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DELAY_CYC);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (!trig_i)     cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign reply_o = trig_i && (cnt_q == LIMIT);

    assert_reply_waits_R8: assert property (@(posedge clk) disable iff (rst)
        (reply_o && (DELAY_CYC != 0)) |-> $past(trig_i));

    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (trig_i && !$past(trig_i) && (DELAY_CYC != 0)) |-> !reply_o);

endmodule

// File: rtl/bsel_decoder.sv
module bsel_decoder #(
    parameter int unsigned ADDR_W    = 3,
    parameter int unsigned DELAY_CYC = 4,
    localparam int unsigned NUM_SEL  = 1 << (ADDR_W - 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sync_i,
    input  logic               enb_i,
    input  logic [ADDR_W-1:0]  dal_i,
    input  logic               wtbt_i,
    input  logic               din_i,
    input  logic               dout_i,
    input  logic               vec_i,
    output logic [NUM_SEL-1:0] sel_o,
    output logic               rd_word_o,
    output logic               wr_lo_o,
    output logic               wr_hi_o,
    output logic               reply_o
);
    logic active;
    logic hit;
    logic a0;
    logic trig;

    bsel_addr_trap #(.ADDR_W(ADDR_W)) u_trap (
        .clk      (clk),
        .rst      (rst),
        .sync_i   (sync_i),
        .enb_i    (enb_i),
        .dal_i    (dal_i),
        .active_o (active),
        .hit_o    (hit),
        .a0_o     (a0),
        .sel_o    (sel_o)
    );

    bsel_strobe_dec u_strobe (
        .clk       (clk),
        .rst       (rst),
        .active_i  (active),
        .din_i     (din_i),
        .dout_i    (dout_i),
        .wtbt_i    (wtbt_i),
        .a0_i      (a0),
        .rd_word_o (rd_word_o),
        .wr_lo_o   (wr_lo_o),
        .wr_hi_o   (wr_hi_o)
    );

    // Address term gated by the captured enable; vector term is unconditional
    assign trig = vec_i || (active && hit && (din_i || dout_i));

    bsel_reply_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .trig_i  (trig),
        .reply_o (reply_o)
    );

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !sync_i |-> (sel_o == '0 && !rd_word_o && !wr_lo_o && !wr_hi_o));

    assert_reply_source_R10: assert property (@(posedge clk) disable iff (rst)
        (reply_o && !sync_i) |-> vec_i);

endmodule

// File: tb/bsel_decoder_tb.sv
module bsel_decoder_tb;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned DLY    = 4;
    localparam int unsigned NSEL   = 1 << (ADDR_W - 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync = 0, enb = 0, wtbt = 0, din = 0, dout = 0, vec = 0;
    logic [ADDR_W-1:0] dal = '0;
    logic [NSEL-1:0] sel;
    logic rd, wlo, whi, rep;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    bsel_decoder #(.ADDR_W(ADDR_W), .DELAY_CYC(DLY)) u_dut (
        .clk(clk), .rst(rst), .sync_i(sync), .enb_i(enb), .dal_i(dal),
        .wtbt_i(wtbt), .din_i(din), .dout_i(dout), .vec_i(vec),
        .sel_o(sel), .rd_word_o(rd), .wr_lo_o(wlo), .wr_hi_o(whi), .reply_o(rep)
    );

    // Reference state built from the requirements
    logic m_sync_q = 0, m_hit = 0;
    logic [ADDR_W-1:0] m_addr = '0;
    int m_cnt = 0;

    function automatic logic m_active();
        return sync && m_sync_q;
    endfunction
    function automatic logic m_trig();
        return vec || (m_active() && m_hit && (din || dout));
    endfunction
    function automatic logic [NSEL-1:0] exp_sel();
        logic [NSEL-1:0] s;
        s = '0;
        if (m_active() && m_hit) s[m_addr[ADDR_W-1:1]] = 1'b1;
        return s;
    endfunction
    function automatic logic exp_lo();
        return m_active() && dout && (!wtbt || !m_addr[0]);
    endfunction
    function automatic logic exp_hi();
        return m_active() && dout && (!wtbt || m_addr[0]);
    endfunction
    function automatic logic exp_rep();
        return m_trig() && (m_cnt >= DLY);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sync_q <= 0; m_hit <= 0; m_addr <= '0; m_cnt <= 0;
        end else begin
            m_sync_q <= sync;
            if (sync && !m_sync_q) begin
                m_addr <= dal; m_hit <= enb;
            end else if (!sync) m_hit <= 0;
            if (!m_trig()) m_cnt <= 0;
            else if (m_cnt < DLY) m_cnt <= m_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, got, exp);
        end
    endtask

    // Compare every output against the reference at the current point
    task automatic cmp_all();
        chk(!sync ? "R11 sel" : "R3 sel", 8'(sel), 8'(exp_sel()));
        chk(!sync ? "R11 rd" : "R5 rd", 8'(rd), 8'(exp_rd()));
        chk(wtbt ? "R7 lo" : "R6 lo", 8'(wlo), 8'(exp_lo()));
        chk(wtbt ? "R7 hi" : "R6 hi", 8'(whi), 8'(exp_hi()));
        chk(vec ? "R10 reply" : "R8 reply", 8'(rep), 8'(exp_rep()));
    endtask
    function automatic logic exp_rd();
        return m_active() && din;
    endfunction

    task automatic step();
        @(posedge clk); cyc++;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd20240611);
        @(negedge clk);
        // R1: outputs quiet in reset even with strobes driven
        sync = 1; din = 1; dout = 1; enb = 1;
        step(); step();
        chk("R1 reset", {rep, whi, wlo, rd, sel}, 8'h00);
        sync = 0; din = 0; dout = 0;
        rst = 0;
        step();
        chk("R1 after reset", {rep, whi, wlo, rd, sel}, 8'h00);

        // R2/R4: address captured, later dal change ignored, held until sync drops
        dal = 3'b100; enb = 1; sync = 1; #1 cmp_all(); step();
        dal = 3'b010; enb = 0; #1 cmp_all();
        chk("R2 capture", 8'(sel), 8'b0100);
        step(); chk("R4 held", 8'(sel), 8'b0100);
        sync = 0; #1 chk("R4 drop", 8'(sel), 8'h00);
        step();

        // Enable low at capture: no select (R3)
        dal = 3'b110; enb = 0; sync = 1; step();
        #1 chk("R3 no enable", 8'(sel), 8'h00);
        sync = 0; step();

        // Byte writes both halves, word write (R6, R7)
        for (int a0 = 0; a0 < 2; a0++) begin
            dal = 3'(a0); enb = 1; sync = 1; step();
            wtbt = 1; dout = 1; #1
            chk("R7 byte", {6'b0, whi, wlo}, (a0 == 1) ? 8'b10 : 8'b01);
            cmp_all();
            wtbt = 0; #1 chk("R6 word", {6'b0, whi, wlo}, 8'b11);
            dout = 0; sync = 0; step();
        end

        // R8/R9: reply delay and restart
        dal = 3'b010; enb = 1; sync = 1; step();
        din = 1;
        for (int k = 0; k < int'(DLY) - 1; k++) step();
        din = 0; #1 chk("R9 break", 8'(rep), 8'h0);
        step();
        din = 1;
        for (int k = 0; k < int'(DLY) - 1; k++) begin
            #1 chk("R9 restart", 8'(rep), 8'h0);
            step();
        end
        #1 chk("R9 pre", 8'(rep), 8'h0);
        step(); #1 chk("R8 reply", 8'(rep), 8'h1);
        din = 0; #1 chk("R8 drop", 8'(rep), 8'h0);
        sync = 0; step();

        // R10: vector with sync low
        vec = 1;
        for (int k = 0; k < int'(DLY); k++) step();
        #1 chk("R10 vector", 8'(rep), 8'h1);
        vec = 0; step();

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 6) == 0) sync = ~sync;
            dal  = ADDR_W'($urandom);
            enb  = ($urandom % 4) != 0;
            wtbt = $urandom % 2;
            din  = ($urandom % 3) == 0;
            dout = ($urandom % 3) == 0;
            if (($urandom % 10) == 0) vec = ~vec;
            #1 cmp_all();
            step();
        end
        finish_run();
    end
endmodule